// File: doc/BRIEF.md
# Data Processing ALU with Condition Flags

This block is the integer execute unit of a load-store RISC core. In a single combinational pass it takes a 4-bit operation code, a first operand and a second operand that has already been through the barrel shifter, and returns a 32-bit result, a write enable for the destination register and the next value of the four condition flags. The sixteen operations cover add and subtract, including carry-in and reverse forms, bitwise logic, register moves, and four compare/test operations that only set flags.

Every operation that adds or subtracts goes through one shared adder. The operands can be swapped and inverted on the way in, and the carry-in is chosen as zero, one or the incoming carry flag. The core's pipeline registers sit on both sides of the block, so it has no clock, no reset and no handshake of its own.

Flags change only when the core asks for it, except for compare/test operations, which always update them. Arithmetic operations rewrite all four flags. Logical operations rewrite N and Z, keep V, and take C from the shifter only when a shift was actually applied.

Top module: `dp_alu`

## Requirements
- R1: The opcode values are 0 AND, 1 EOR, 2 SUB, 3 RSB, 4 ADD, 5 ADC, 6 SBC, 7 RSC, 8 TST, 9 TEQ, 10 CMP, 11 CMN, 12 ORR, 13 MOV, 14 BIC, 15 MVN. The arithmetic results, modulo 2^32 with C the carry flag in, are: ADD a+b, ADC a+b+C, SUB a-b, SBC a-b+C-1, RSB b-a, RSC b-a+C-1.
- R2: The logical results are: AND a&b, EOR a^b, ORR a|b, BIC a&~b, MOV b, MVN ~b.
- R3: CMP, CMN, TST and TEQ drive wr_en_o low. Their result_o shows the internal value a-b, a+b, a&b or a^b respectively.
- R4: Every other operation drives wr_en_o high.
- R5: flags_i and flags_o are packed as bit 3 N, bit 2 Z, bit 1 C, bit 0 V. For a non-compare operation with set_flags_i low, flags_o equals flags_i.
- R6: The four compare/test operations update the flags whether set_flags_i is high or low.
- R7: An updating arithmetic operation sets C to the carry out of the 32-bit addition. For the subtract forms this is NOT borrow, so C=1 means the subtraction did not borrow.
- R8: An updating arithmetic operation sets V when the signed result does not fit in 32 bits.
- R9: Whenever the flags update, N equals result_o bit 31 and Z is 1 exactly when result_o is zero.
- R10: An updating logical operation keeps V. Its C equals shift_carry_i when shift_used_i is high and keeps the incoming C otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code (R1 encoding) |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand, already shifted |
| shift_carry_i | input | 1 | Carry out of the shifter |
| shift_used_i | input | 1 | A shift was applied to opb_i |
| flags_i | input | 4 | Current N,Z,C,V |
| set_flags_i | input | 1 | Request to update flags |
| result_o | output | 32 | Operation result |
| wr_en_o | output | 1 | Destination register write enable |
| flags_o | output | 4 | Next N,Z,C,V |

## Verification
The bench goes after the edges of the adder. Signed overflow at 0x7FFFFFFF+1 and 0x80000000-1 checks V: a design that compared the wrong sign bits would miss V or raise it falsely. Unsigned wrap to zero and subtracting equal operands check C and Z: a design that treated C as borrow would report the opposite carry for every subtract. ADC, SBC and RSC run with C both set and clear, since a wrong carry-in selection shifts those results by one. Logical operations run with and without a shift applied, and every operation runs with set_flags_i low, so that a V overwritten by a logical operation or flags leaking through without a request both show at flags_o.

// File: rtl/dp_alu_pkg.sv
`timescale 1ns/1ps
package dp_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
    OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
    OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {CIN_ZERO, CIN_ONE, CIN_FLAG} cin_sel_e;

  typedef enum logic [2:0] {
    LG_AND, LG_XOR, LG_OR, LG_ANDN, LG_PASSB, LG_NOTB
  } logic_sel_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  typedef struct packed {
    logic       arith;
    logic       compare;
    logic       swap;
    logic       invert;
    cin_sel_e   cin_sel;
    logic_sel_e lsel;
  } ctrl_t;

endpackage

// File: rtl/dp_alu_decode.sv
`timescale 1ns/1ps
module dp_alu_decode
  import dp_alu_pkg::*;
(
  input  logic [3:0] op_i,
  output ctrl_t      ctrl_o
);

  alu_op_e op;
  assign op = alu_op_e'(op_i);

  always_comb begin
    ctrl_o         = '0;
    ctrl_o.cin_sel = CIN_ZERO;
    ctrl_o.lsel    = LG_AND;
    ctrl_o.compare = (op_i[3:2] == 2'b10);
    unique case (op)
      OP_AND, OP_TST: ctrl_o.lsel = LG_AND;
      OP_EOR, OP_TEQ: ctrl_o.lsel = LG_XOR;
      OP_ORR:         ctrl_o.lsel = LG_OR;
      OP_BIC:         ctrl_o.lsel = LG_ANDN;
      OP_MOV:         ctrl_o.lsel = LG_PASSB;
      OP_MVN:         ctrl_o.lsel = LG_NOTB;
      OP_ADD, OP_CMN: ctrl_o.arith = 1'b1;
      OP_ADC: begin
        ctrl_o.arith   = 1'b1;
        ctrl_o.cin_sel = CIN_FLAG;
      end
      OP_SUB, OP_CMP: begin
        ctrl_o.arith   = 1'b1;
        ctrl_o.invert  = 1'b1;
        ctrl_o.cin_sel = CIN_ONE;
      end
      OP_SBC: begin
        ctrl_o.arith   = 1'b1;
        ctrl_o.invert  = 1'b1;
        ctrl_o.cin_sel = CIN_FLAG;
      end
      OP_RSB: begin
        ctrl_o.arith   = 1'b1;
        ctrl_o.swap    = 1'b1;
        ctrl_o.invert  = 1'b1;
        ctrl_o.cin_sel = CIN_ONE;
      end
      OP_RSC: begin
        ctrl_o.arith   = 1'b1;
        ctrl_o.swap    = 1'b1;
        ctrl_o.invert  = 1'b1;
        ctrl_o.cin_sel = CIN_FLAG;
      end
      default: ctrl_o.lsel = LG_AND;
    endcase
  end

endmodule

// File: rtl/dp_alu_adder.sv
`timescale 1ns/1ps
module dp_alu_adder #(
  parameter int W = 32
) (
  input  logic         swap_i,
  input  logic         invert_i,
  input  logic         cin_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         ovf_o
);

  localparam int MSB = W - 1;

  logic [W-1:0] x, y;
  logic [W:0]   total;

  // The operand in the first position stays true; the other one is inverted for subtract forms.
  assign x = swap_i ? b_i : a_i;
  assign y = invert_i ? ~(swap_i ? a_i : b_i) : (swap_i ? a_i : b_i);

  assign total  = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin_i};
  assign sum_o  = total[W-1:0];
  assign cout_o = total[W];
  assign ovf_o  = (x[MSB] == y[MSB]) && (total[MSB] != x[MSB]);

endmodule

// File: rtl/dp_alu_logic.sv
`timescale 1ns/1ps
module dp_alu_logic
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic_sel_e   sel_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] res_o
);

  always_comb begin
    unique case (sel_i)
      LG_AND:   res_o = a_i & b_i;
      LG_XOR:   res_o = a_i ^ b_i;
      LG_OR:    res_o = a_i | b_i;
      LG_ANDN:  res_o = a_i & ~b_i;
      LG_PASSB: res_o = b_i;
      LG_NOTB:  res_o = ~b_i;
      default:  res_o = a_i & b_i;
    endcase
  end

endmodule

// File: rtl/dp_alu_flags.sv
`timescale 1ns/1ps
module dp_alu_flags
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         arith_i,
  input  logic         compare_i,
  input  logic         set_flags_i,
  input  logic         shift_used_i,
  input  logic         shift_carry_i,
  input  logic [W-1:0] res_i,
  input  logic         cout_i,
  input  logic         ovf_i,
  input  flags_t       flags_i,
  output flags_t       flags_o
);

  logic update;
  assign update = set_flags_i || compare_i;

  always_comb begin
    flags_o = flags_i;
    if (update) begin
      flags_o.n = res_i[W-1];
      flags_o.z = (res_i == '0);
      if (arith_i) begin
        flags_o.c = cout_i;
        flags_o.v = ovf_i;
      end else begin
        flags_o.c = shift_used_i ? shift_carry_i : flags_i.c;
      end
    end
  end

endmodule

// File: rtl/dp_alu.sv
`timescale 1ns/1ps
module dp_alu
  import dp_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0]   op_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  input  logic         shift_carry_i,
  input  logic         shift_used_i,
  input  logic [3:0]   flags_i,
  input  logic         set_flags_i,
  output logic [W-1:0] result_o,
  output logic         wr_en_o,
  output logic [3:0]   flags_o
);

  ctrl_t        ctrl;
  flags_t       cur_flags, next_flags;
  logic [W-1:0] sum, lres;
  logic         cout, ovf, cin;

  assign cur_flags = flags_t'(flags_i);

  dp_alu_decode u_decode (
    .op_i   (op_i),
    .ctrl_o (ctrl)
  );

  always_comb begin
    unique case (ctrl.cin_sel)
      CIN_ONE:  cin = 1'b1;
      CIN_FLAG: cin = cur_flags.c;
      default:  cin = 1'b0;
    endcase
  end

  dp_alu_adder #(.W(W)) u_adder (
    .swap_i   (ctrl.swap),
    .invert_i (ctrl.invert),
    .cin_i    (cin),
    .a_i      (opa_i),
    .b_i      (opb_i),
    .sum_o    (sum),
    .cout_o   (cout),
    .ovf_o    (ovf)
  );

  dp_alu_logic #(.W(W)) u_logic (
    .sel_i (ctrl.lsel),
    .a_i   (opa_i),
    .b_i   (opb_i),
    .res_o (lres)
  );

  assign result_o = ctrl.arith ? sum : lres;
  assign wr_en_o  = ~ctrl.compare;

  dp_alu_flags #(.W(W)) u_flags (
    .arith_i       (ctrl.arith),
    .compare_i     (ctrl.compare),
    .set_flags_i   (set_flags_i),
    .shift_used_i  (shift_used_i),
    .shift_carry_i (shift_carry_i),
    .res_i         (result_o),
    .cout_i        (cout),
    .ovf_i         (ovf),
    .flags_i       (cur_flags),
    .flags_o       (next_flags)
  );

  assign flags_o = next_flags;

endmodule

// File: rtl/dp_alu_chk.sv
`timescale 1ns/1ps
module dp_alu_chk #(
  parameter int W = 32
) (
  input logic [3:0]   op_i,
  input logic [W-1:0] opa_i,
  input logic [W-1:0] opb_i,
  input logic         shift_carry_i,
  input logic         shift_used_i,
  input logic [3:0]   flags_i,
  input logic         set_flags_i,
  input logic [W-1:0] result_o,
  input logic         wr_en_o,
  input logic [3:0]   flags_o
);

  logic is_cmp, is_logic, upd;
  assign is_cmp   = (op_i >= 4'd8) && (op_i <= 4'd11);
  assign is_logic = (op_i <= 4'd1) || (op_i == 4'd8) || (op_i == 4'd9) || (op_i >= 4'd12);
  assign upd      = set_flags_i || is_cmp;

  always_comb begin
    // R3
    cmp_no_write_chk: assert (!is_cmp || !wr_en_o) else $error("compare op wrote result");
    // R4
    op_write_chk: assert (is_cmp || wr_en_o) else $error("data op did not write");
    // R5
    hold_flags_chk: assert (upd || flags_o == flags_i) else $error("flags changed without request");
    // R9
    n_flag_chk: assert (!upd || flags_o[3] == result_o[W-1]) else $error("N mismatch");
    // R9
    z_flag_chk: assert (!upd || flags_o[2] == (result_o == '0)) else $error("Z mismatch");
    // R10
    v_keep_chk: assert (!(upd && is_logic) || flags_o[0] == flags_i[0]) else $error("logic op changed V");
    // R10
    c_logic_chk: assert (!(upd && is_logic) ||
                         flags_o[1] == (shift_used_i ? shift_carry_i : flags_i[1]))
      else $error("logic op C wrong");
    // R2
    mov_pass_chk: assert (op_i != 4'd13 || result_o == opb_i) else $error("MOV result wrong");
    // R2
    eor_chk: assert (op_i != 4'd1 || result_o == (opa_i ^ opb_i)) else $error("EOR result wrong");
  end

endmodule

bind dp_alu dp_alu_chk #(.W(W)) u_chk (.*);

// File: tb/dp_alu_bench.sv
`timescale 1ns/1ps
module dp_alu_bench;

  logic        clk = 1'b0;
  logic [3:0]  op;
  logic [31:0] opa, opb;
  logic        sc, su, sf;
  logic [3:0]  fi;
  logic [31:0] result;
  logic        wr_en;
  logic [3:0]  fo;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  dp_alu u_dp_alu (
    .op_i          (op),
    .opa_i         (opa),
    .opb_i         (opb),
    .shift_carry_i (sc),
    .shift_used_i  (su),
    .flags_i       (fi),
    .set_flags_i   (sf),
    .result_o      (result),
    .wr_en_o       (wr_en),
    .flags_o       (fo)
  );

  // Behavioural reference: wide signed/unsigned arithmetic, no adder structure.
  task automatic model(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                       input logic shc, input logic shu, input logic [3:0] f, input logic sfl,
                       output logic [31:0] r, output logic we, output logic [3:0] fx);
    longint ua, ub, sa, sb, u, s, ci;
    bit arith, cmp, cflag, vflag;
    ua = longint'({32'b0, a});
    ub = longint'({32'b0, b});
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    ci = f[1] ? 64'sd1 : 64'sd0;
    arith = 1'b0; u = 0; s = 0; cflag = 1'b0; r = '0;
    case (o)
      4'd4, 4'd11: begin arith = 1; u = ua + ub;      s = sa + sb;      end
      4'd5:        begin arith = 1; u = ua + ub + ci; s = sa + sb + ci; end
      4'd2, 4'd10: begin arith = 1; u = ua - ub;      s = sa - sb;      end
      4'd6:        begin arith = 1; u = ua - ub + ci - 1; s = sa - sb + ci - 1; end
      4'd3:        begin arith = 1; u = ub - ua;      s = sb - sa;      end
      4'd7:        begin arith = 1; u = ub - ua + ci - 1; s = sb - sa + ci - 1; end
      4'd0, 4'd8:  r = a & b;
      4'd1, 4'd9:  r = a ^ b;
      4'd12:       r = a | b;
      4'd13:       r = b;
      4'd14:       r = a & ~b;
      default:     r = ~b;
    endcase
    if (arith) begin
      r = u[31:0];
      if (o == 4'd4 || o == 4'd5 || o == 4'd11) cflag = (u >= 64'sd4294967296);
      else cflag = (u >= 0);
    end
    vflag = (s > 64'sd2147483647) || (s < -64'sd2147483648);
    cmp = (o >= 4'd8) && (o <= 4'd11);
    we  = !cmp;
    fx  = f;
    if (sfl || cmp) begin
      fx[3] = r[31];
      fx[2] = (r == 32'd0);
      if (arith) begin
        fx[1] = cflag;
        fx[0] = vflag;
      end else if (shu) begin
        fx[1] = shc;
      end
    end
  endtask

  task automatic apply(input logic [3:0] o, input logic [31:0] a, input logic [31:0] b,
                       input logic shc, input logic shu, input logic [3:0] f,
                       input logic sfl, input string tag);
    logic [31:0] er;
    logic        ew;
    logic [3:0]  ef;
    @(posedge clk);
    #1;
    op = o; opa = a; opb = b; sc = shc; su = shu; fi = f; sf = sfl;
    model(o, a, b, shc, shu, f, sfl, er, ew, ef);
    @(negedge clk);
    total++;
    if (result !== er || wr_en !== ew || fo !== ef) begin
      bad++;
      $display("FAIL %s op=%0d a=%h b=%h: actual res=%h we=%b nzcv=%b expected res=%h we=%b nzcv=%b",
               tag, o, a, b, result, wr_en, fo, er, ew, ef);
    end
  endtask

  function automatic string tag_of(input logic [3:0] o, input logic sfl);
    if (o >= 4'd8 && o <= 4'd11) return "R3/R6/R9";
    if (!sfl) return "R4/R5";
    if (o >= 4'd2 && o <= 4'd7) return "R1/R7/R8/R9";
    return "R2/R10";
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog R1: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    op = 4'd0; opa = '0; opb = '0; sc = 0; su = 0; fi = 4'b0000; sf = 0;
    // Idle state with all-zero inputs: AND of zeros, write enabled, flags held (R4)
    @(negedge clk);
    total++;
    if (result !== 32'd0 || wr_en !== 1'b1 || fo !== 4'b0000) begin
      bad++;
      $display("FAIL R4 idle: actual res=%h we=%b nzcv=%b expected res=0 we=1 nzcv=0000",
               result, wr_en, fo);
    end

    // R8: positive overflow on ADD
    apply(4'd4, 32'h7FFFFFFF, 32'h1, 0, 0, 4'b0000, 1, "R8");
    // R7: unsigned wrap to zero sets C and Z
    apply(4'd4, 32'hFFFFFFFF, 32'h1, 0, 0, 4'b0000, 1, "R7");
    // R7: equal SUB gives Z=1, C=1 (no borrow)
    apply(4'd2, 32'h1234, 32'h1234, 0, 0, 4'b0000, 1, "R7");
    // R7: 0-1 borrows, C=0, N=1
    apply(4'd2, 32'h0, 32'h1, 0, 0, 4'b0010, 1, "R7");
    // R8: negative overflow on SUB
    apply(4'd2, 32'h80000000, 32'h1, 0, 0, 4'b0000, 1, "R8");
    // R1: reverse subtract
    apply(4'd3, 32'd5, 32'd12, 0, 0, 4'b0000, 1, "R1");
    // R1: carry-in forms with C set and clear
    apply(4'd5, 32'hFFFFFFFF, 32'h0, 0, 0, 4'b0010, 1, "R1");
    apply(4'd5, 32'hFFFFFFFF, 32'h0, 0, 0, 4'b0000, 1, "R1");
    apply(4'd6, 32'd10, 32'd3, 0, 0, 4'b0000, 1, "R1");
    apply(4'd6, 32'd10, 32'd3, 0, 0, 4'b0010, 1, "R1");
    apply(4'd7, 32'd3, 32'd10, 0, 0, 4'b0000, 1, "R1");
    // R10: logical op keeps V, takes C from the shifter only when shifted
    apply(4'd0, 32'hF0F0F0F0, 32'hFFFF0000, 1, 1, 4'b0001, 1, "R10");
    apply(4'd0, 32'hF0F0F0F0, 32'hFFFF0000, 0, 0, 4'b0011, 1, "R10");
    apply(4'd13, 32'h0, 32'h0, 0, 1, 4'b1011, 1, "R10");
    // R2: BIC and MVN
    apply(4'd14, 32'hFFFF00FF, 32'h0F0F0F0F, 0, 0, 4'b0000, 0, "R2");
    apply(4'd15, 32'h0, 32'h12345678, 0, 0, 4'b0000, 0, "R2");
    // R5: arithmetic without a request leaves flags alone
    apply(4'd4, 32'hFFFFFFFF, 32'h1, 0, 0, 4'b1001, 0, "R5");
    // R6: CMP and TST with set_flags low still update, R3: no write
    apply(4'd10, 32'd7, 32'd7, 0, 0, 4'b0000, 0, "R6");
    apply(4'd8, 32'hF0, 32'h0F, 1, 1, 4'b0001, 0, "R6");
    apply(4'd11, 32'h7FFFFFFF, 32'h7FFFFFFF, 0, 0, 4'b0000, 0, "R3");
    apply(4'd9, 32'hAAAA5555, 32'hAAAA5555, 0, 0, 4'b0000, 0, "R3");

    // Random sweep across all sixteen operations
    for (int i = 0; i < 4000; i++) begin
      logic [3:0]  o;
      logic [31:0] a, b;
      o = 4'(i % 16);
      a = $urandom;
      b = $urandom;
      case ($urandom % 8)
        0: a = 32'h80000000;
        1: b = 32'h7FFFFFFF;
        2: b = a;
        3: a = 32'hFFFFFFFF;
        default: ;
      endcase
      apply(o, a, b, 1'($urandom), 1'($urandom), 4'($urandom), 1'($urandom),
            tag_of(o, sf));
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule